// File: doc/BRIEF.md
# Programmable Power-Good Delay Sequencer

This block generates three power-good outputs for a power-management device. Each output watches its own group of regulator "in regulation" flags. The group is chosen by a per-pin bit mask. The output asserts only after a programmable delay, measured from the moment every rail in the group is good at the same time.

The delay for each pin comes from a field in an 8-bit delay register, decoded through a non-linear millisecond table. Pin A has a 2-bit field that reaches only the first four table entries. Pins B and C have 3-bit fields. Time is counted in ticks of a shared prescaler; one tick is nominally 1 ms and lasts `TICK_DIV` clocks.

A second register can place any pin in direct mode. In direct mode a register bit drives the pin, and the rails and the delay have no effect. Rail flags are asynchronous, so they pass through two-flop synchronisers before they are combined.

Top module: `pgd_seq`

## Requirements
- R1: Address 0 is the delay register: bits 7:5 hold pin B's code, bits 4:2 hold pin C's code, bits 1:0 hold pin A's code. Address 1 is the control register: bit i (i=0 A, 1 B, 2 C) selects direct mode for pin i, and bit 4+i is that pin's direct level. Bits 7 and 3 of the control register read as 0. Both registers reset to 0 and read back what was written. All outputs reset low.
- R2: For pins B and C, codes 0 to 7 select 0, 5, 10, 15, 20, 50, 75 and 100 ticks. A delay of N≥1 ticks asserts the output no earlier than (N-1)·TICK_DIV+3 clocks and no later than N·TICK_DIV+3 clocks after the rails become good.
- R3: Pin A's 2-bit code selects 0, 5, 10 or 15 ticks, with the same timing window as R2.
- R4: A code of zero asserts the output exactly 3 clocks after the last rail of the group becomes good: two synchroniser stages, then the output register.
- R5: If any rail in a group leaves regulation, the pin deasserts exactly 3 clocks after the input change and its timer clears. When the group is good again, the full delay starts over.
- R6: A delay code written during a count takes effect in the clock after the write. The output asserts once the elapsed count is at or above the new target, and drops if the new target is above the elapsed count.
- R7: A pin whose group mask is all zeros stays deasserted in power-good mode, whatever the rails are.
- R8: In direct mode the pin equals its direct-level bit one clock after the control write. The rails and the delay field are ignored.
- R9: Pin i's mask is `grp_mask[i*NRAIL +: NRAIL]`, and `pg_out[i]` is pin i (0 A, 1 B, 2 C).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 delay, 1 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| rail_good | input | NRAIL | Asynchronous rail in-regulation flags |
| grp_mask | input | 3*NRAIL | Per-pin rail group masks |
| pg_out | output | 3 | Power-good outputs, pins A, B, C |

## Verification
Rail changes reach a zero-delay output exactly 3 clocks after the input moves, and a deassertion takes the same 3 clocks. The bench therefore checks one clock before and at that edge.

For a non-zero delay the free-running tick makes the exact edge phase-dependent. The bench checks the output low at (N-1)·TICK_DIV+3 clocks and high at N·TICK_DIV+3 clocks, which holds at any prescaler phase.

Register writes, including code changes mid-count and direct-mode changes, appear on the pins at the second edge after the write strobe is driven, and are sampled there. Randomised configurations are checked only after more than the longest delay has passed, so their expected levels depend on the steady state alone.

// File: rtl/pgd_pkg.sv
package pgd_pkg;

  localparam int REG_W  = 8;
  localparam int CODE_MAX_W = 3;
  localparam int ELAP_W = 7;

  typedef logic [ELAP_W-1:0] tick_cnt_t;

  // Non-linear delay table, in ticks
  function automatic tick_cnt_t code_to_ticks(input logic [CODE_MAX_W-1:0] c);
    tick_cnt_t r;
    case (c)
      3'd0:    r = 7'd0;
      3'd1:    r = 7'd5;
      3'd2:    r = 7'd10;
      3'd3:    r = 7'd15;
      3'd4:    r = 7'd20;
      3'd5:    r = 7'd50;
      3'd6:    r = 7'd75;
      default: r = 7'd100;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pgd_sync.sv
module pgd_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_async;
      stab_q <= meta_q;
    end
  end

  assign q_sync = stab_q;

endmodule

// File: rtl/pgd_tick.sv
module pgd_tick #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_comb begin
    if (wrap) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = wrap;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  generate
    if (DIV > 1) begin : g_spaced
      // R2
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/pgd_regs.sv
module pgd_regs
  import pgd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] dly_cfg,
  output logic [2:0]       dir_en,
  output logic [2:0]       dir_lvl
);

  logic [REG_W-1:0] dly_q, dly_d;
  logic [2:0]       en_q, en_d;
  logic [2:0]       lvl_q, lvl_d;
  logic             wr_dly, wr_ctl;

  assign wr_dly = wr && (addr == 1'b0);
  assign wr_ctl = wr && (addr == 1'b1);

  always_comb begin
    dly_d = dly_q;
    en_d  = en_q;
    lvl_d = lvl_q;
    if (wr_dly) dly_d = wdata;
    if (wr_ctl) begin
      en_d  = wdata[2:0];
      lvl_d = wdata[6:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      en_q  <= '0;
      lvl_q <= '0;
    end else begin
      dly_q <= dly_d;
      en_q  <= en_d;
      lvl_q <= lvl_d;
    end
  end

  always_comb begin
    if (addr) rdata = {1'b0, lvl_q, 1'b0, en_q};
    else      rdata = dly_q;
  end

  assign dly_cfg = dly_q;
  assign dir_en  = en_q;
  assign dir_lvl = lvl_q;

  // R1
  dly_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !addr) |=> (dly_cfg == $past(wdata)));

  // R1
  ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr) |=> (dir_en == $past(wdata[2:0])) && (dir_lvl == $past(wdata[6:4])));

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(dly_cfg) && $stable(dir_en) && $stable(dir_lvl));

endmodule

// File: rtl/pgd_channel.sv
module pgd_channel
  import pgd_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              grp_ok,
  input  logic [CODE_W-1:0] code,
  input  logic              dir_en,
  input  logic              dir_lvl,
  output logic              pg
);

  logic [CODE_MAX_W-1:0] code_x;
  tick_cnt_t             target;
  tick_cnt_t             elap_q, elap_d;
  logic                  pg_q, pg_d;
  logic                  elap_sat;
  logic                  reached;

  generate
    if (CODE_W < CODE_MAX_W) begin : g_short
      assign code_x = {{(CODE_MAX_W-CODE_W){1'b0}}, code};
    end else begin : g_full
      assign code_x = code;
    end
  endgenerate

  assign target   = code_to_ticks(code_x);
  assign elap_sat = &elap_q;
  assign reached  = (elap_q >= target);

  always_comb begin
    if (!grp_ok)                elap_d = '0;
    else if (tick && !elap_sat) elap_d = elap_q + 1'b1;
    else                        elap_d = elap_q;
  end

  always_comb begin
    if (dir_en) pg_d = dir_lvl;
    else        pg_d = grp_ok && reached;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elap_q <= '0;
      pg_q   <= 1'b0;
    end else begin
      elap_q <= elap_d;
      pg_q   <= pg_d;
    end
  end

  assign pg = pg_q;

  // R5
  drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_ok |=> (elap_q == '0));

  // R5
  drop_deasserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_ok && !dir_en) |=> !pg);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_ok |=> (elap_q == $past(elap_q)) || (elap_q == $past(elap_q) + 7'd1));

  // R6
  rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pg) && !$past(dir_en)) |-> ($past(elap_q) >= $past(target)));

  // R8
  direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_en |=> (pg == $past(dir_lvl)));

endmodule

// File: rtl/pgd_seq.sv
module pgd_seq
  import pgd_pkg::*;
#(
  parameter int NRAIL    = 8,
  parameter int TICK_DIV = 50000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NRAIL-1:0]     rail_good,
  input  logic [3*NRAIL-1:0]   grp_mask,
  output logic [2:0]           pg_out
);

  localparam int NPIN = 3;

  logic [REG_W-1:0] dly_cfg;
  logic [NPIN-1:0]  dir_en;
  logic [NPIN-1:0]  dir_lvl;
  logic [NRAIL-1:0] rail_s;
  logic             tick;

  pgd_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .dly_cfg (dly_cfg),
    .dir_en  (dir_en),
    .dir_lvl (dir_lvl)
  );

  pgd_sync #(.WIDTH(NRAIL)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rail_good),
    .q_sync  (rail_s)
  );

  pgd_tick #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  genvar p;
  generate
    for (p = 0; p < NPIN; p++) begin : g_pin
      // Field placement is fixed by the register layout (R1)
      localparam int CW  = (p == 0) ? 2 : 3;
      localparam int LSB = (p == 0) ? 0 : ((p == 1) ? 5 : 2);

      logic [NRAIL-1:0] msk;
      logic             grp_ok;

      assign msk    = grp_mask[p*NRAIL +: NRAIL];
      assign grp_ok = (|msk) && ((rail_s & msk) == msk);

      pgd_channel #(.CODE_W(CW)) u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .grp_ok  (grp_ok),
        .code    (dly_cfg[LSB +: CW]),
        .dir_en  (dir_en[p]),
        .dir_lvl (dir_lvl[p]),
        .pg      (pg_out[p])
      );

      // R7
      empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((msk == '0) && !dir_en[p]) |=> !pg_out[p]);

      // R5
      rail_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((rail_s & msk) != msk) && !dir_en[p]) |=> !pg_out[p]);
    end
  endgenerate

endmodule

// File: tb/pgd_seq_tb.sv
module pgd_seq_tb;

  localparam int NR  = 8;
  localparam int DIV = 20;

  logic          clk;
  logic          rst_n;
  logic          reg_wr;
  logic          reg_addr;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;
  logic [NR-1:0] rail_good;
  logic [3*NR-1:0] grp_mask;
  logic [2:0]    pg_out;

  int n_run  = 0;
  int n_fail = 0;

  pgd_seq #(.NRAIL(NR), .TICK_DIV(DIV)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rail_good (rail_good),
    .grp_mask  (grp_mask),
    .pg_out    (pg_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int ticks_of(input int pin, input int code);
    int t [8] = '{0, 5, 10, 15, 20, 50, 75, 100};
    if (pin == 0) return t[code & 3];
    return t[code & 7];
  endfunction

  function automatic logic grp_good(input logic [NR-1:0] m, input logic [NR-1:0] r);
    return (m != '0) && ((r & m) == m);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wait_edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_reg(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
  endtask

  task automatic delay_case(input int pin, input int code);
    logic [7:0] cfg;
    int n, klo, khi;
    string tag;
    rail_good = '0;
    grp_mask  = {3{8'hFF}};
    wait_edges(5);
    if (pin == 0)      cfg = {6'b0, 2'(code)};
    else if (pin == 1) cfg = {3'(code), 5'b0};
    else               cfg = {3'b0, 3'(code), 2'b0};
    write_reg(1'b0, cfg);
    n = ticks_of(pin, code);
    tag = (n == 0) ? "R4" : ((pin == 0) ? "R3" : "R2");
    rail_good = '1;
    if (n == 0) begin klo = 2; khi = 3; end
    else begin klo = (n - 1) * DIV + 3; khi = n * DIV + 3; end
    wait_edges(klo);
    chk($sformatf("%s pin%0d code%0d early", tag, pin, code), {7'b0, pg_out[pin]}, 8'd0);
    wait_edges(khi - klo);
    chk($sformatf("%s pin%0d code%0d due", tag, pin, code), {7'b0, pg_out[pin]}, 8'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] rnd_dly, rnd_ctl;
    logic [NR-1:0] rails;
    logic [3*NR-1:0] masks;
    void'($urandom(32'd4242));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    rail_good = '0; grp_mask = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    wait_edges(1);

    // R1 reset state
    chk("R1 reset pg", {5'b0, pg_out}, 8'd0);
    reg_addr = 1'b0; #1 chk("R1 reset delay reg", reg_rdata, 8'd0);
    reg_addr = 1'b1; #1 chk("R1 reset ctl reg", reg_rdata, 8'd0);
    reg_addr = 1'b0;
    @(negedge clk);

    // R1 readback
    write_reg(1'b0, 8'hA7);
    #1 chk("R1 delay readback", reg_rdata, 8'hA7);
    @(negedge clk);
    write_reg(1'b1, 8'hFF);
    reg_addr = 1'b1; #1 chk("R1 ctl readback masked", reg_rdata, 8'h77);
    reg_addr = 1'b0;
    @(negedge clk);
    write_reg(1'b1, 8'h00);
    write_reg(1'b0, 8'h00);

    // R2, R3, R4: full table per pin, R9 pin mapping
    for (int c = 0; c < 4; c++) delay_case(0, c);
    for (int c = 0; c < 8; c++) delay_case(1, c);
    for (int c = 0; c < 8; c++) delay_case(2, c);

    // R5: deassert latency with zero delay
    rail_good = '0; grp_mask = {3{8'hFF}};
    write_reg(1'b0, 8'h00);
    wait_edges(4);
    rail_good = '1;
    wait_edges(3);
    chk("R5 pins up", {5'b0, pg_out}, 8'h07);
    rail_good[3] = 1'b0;
    wait_edges(2);
    chk("R5 pins still up one before", {5'b0, pg_out}, 8'h07);
    wait_edges(1);
    chk("R5 pins down at 3", {5'b0, pg_out}, 8'h00);

    // R5: timer restart after a short dropout (pin A, 5 ticks)
    write_reg(1'b0, 8'h01);
    rail_good = '1;
    wait_edges(3 * DIV);
    chk("R5 pin A still counting", {7'b0, pg_out[0]}, 8'd0);
    rail_good = '0;
    wait_edges(4);
    rail_good = '1;
    wait_edges(4 * DIV + 3);
    chk("R5 restart full delay early", {7'b0, pg_out[0]}, 8'd0);
    wait_edges(DIV);
    chk("R5 restart full delay due", {7'b0, pg_out[0]}, 8'd1);

    // R6: code change mid-count (pin B)
    rail_good = '0;
    write_reg(1'b0, {3'd7, 5'b0});
    wait_edges(4);
    rail_good = '1;
    wait_edges(30 * DIV);
    chk("R6 before shorten", {7'b0, pg_out[1]}, 8'd0);
    write_reg(1'b0, {3'd4, 5'b0});
    wait_edges(1);
    chk("R6 shorten asserts", {7'b0, pg_out[1]}, 8'd1);
    write_reg(1'b0, {3'd6, 5'b0});
    wait_edges(1);
    chk("R6 lengthen drops", {7'b0, pg_out[1]}, 8'd0);

    // R7: empty mask on A and C
    rail_good = '0;
    write_reg(1'b0, 8'h00);
    grp_mask = {8'h00, 8'h0F, 8'h00};
    wait_edges(4);
    rail_good = '1;
    wait_edges(10);
    chk("R7 empty masks low, B up", {5'b0, pg_out}, 8'h02);

    // R8: direct mode ignores rails and delay
    grp_mask = {3{8'hFF}};
    rail_good = '0;
    write_reg(1'b0, 8'hFF);
    wait_edges(4);
    write_reg(1'b1, 8'h57);
    wait_edges(1);
    chk("R8 direct levels no rails", {5'b0, pg_out}, 8'h05);
    rail_good = '1;
    wait_edges(10);
    chk("R8 direct levels with rails", {5'b0, pg_out}, 8'h05);
    write_reg(1'b1, 8'h00);
    wait_edges(1);
    chk("R8 back to pg mode counting", {5'b0, pg_out}, 8'h00);

    // Random configurations, steady-state checks
    for (int it = 0; it < 8; it++) begin
      logic [2:0] exp_pg;
      rails   = NR'($urandom);
      if (it[0]) rails = '1;
      masks   = 24'($urandom) & {3{8'($urandom)}};
      if (it == 3) masks[7:0] = '0;
      rnd_dly = 8'($urandom);
      rnd_ctl = 8'($urandom) & 8'h77;
      if (it[1]) rnd_ctl[2:0] = 3'b000;
      rail_good = '0;
      grp_mask  = masks;
      wait_edges(4);
      write_reg(1'b0, rnd_dly);
      write_reg(1'b1, rnd_ctl);
      rail_good = rails;
      wait_edges(101 * DIV + 5);
      for (int p = 0; p < 3; p++)
        exp_pg[p] = rnd_ctl[p] ? rnd_ctl[4+p] : grp_good(masks[p*NR +: NR], rails);
      chk($sformatf("R2 R7 R8 R9 random %0d steady", it), {5'b0, pg_out}, {5'b0, exp_pg});
      rail_good = '0;
      wait_edges(3);
      for (int p = 0; p < 3; p++)
        exp_pg[p] = rnd_ctl[p] ? rnd_ctl[4+p] : 1'b0;
      chk($sformatf("R5 R8 random %0d rails lost", it), {5'b0, pg_out}, {5'b0, exp_pg});
      write_reg(1'b1, 8'h00);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule